// File: doc/BRIEF.md
# Memory Trace Record and Replay Checker

This unit sits between an execution engine's memory request port and the real memory port. A mode input selects what it does with each access.

In record mode it passes every access through to memory. It also appends a trace entry holding the operation kind, the address and a value. Later the same engine, or a second one, runs the same code again in check mode. The unit then walks the trace in order and compares each incoming access with the next entry. It returns read data from the trace, so memory is not touched, and it raises sticky error flags when the two runs diverge.

Writes to the store-queue address window are treated differently from all other accesses. They are never logged. During replay they are still sent to memory, with no comparison. A clear input empties the trace and drops every flag. A start-replay pulse, or a rising edge on the mode input, rewinds the replay pointer. An end-of-replay pulse reports any entries that were recorded but never consumed.

Top module: `memTraceChecker`

## Requirements
- R1: After reset, and in the cycle after a `clearTrace` pulse, all four error flags are low and the trace holds no entries. A check-mode access made then raises the unexpected-operation flag.
- R2: With `modeCheck` low, every valid access appears on the memory port in the same cycle (`memValid` high), and `rspData` equals `memRdata`.
- R3: Kind codes are: 0 read long, 1 read word, 2 read byte, 3 read byte for write, 4 write long, 5 write word, 6 write byte, 7 prefetch. In record mode each logged entry keeps the kind, the address and a value. The value is `memRdata` for kinds 0 to 3, `reqWdata` for kinds 4 to 6, and zero for kind 7.
- R4: A write (kind 4 to 6) whose address satisfies `(addr & 0xFC000000) == 0xE0000000` is forwarded in record mode but never logged.
- R5: In check mode, a read or prefetch that has a trace entry to match makes no memory access. For reads, `rspData` is the logged value of the current entry.
- R6: In check mode, a write in the store-queue window is forwarded to memory. It is not compared and does not advance the replay pointer. Any other write is compared only and is never forwarded.
- R7: A check-mode access that arrives when the replay pointer equals the entry count sets `errUnexpected`.
- R8: In check mode, a difference from the current entry sets `errMismatch`. A difference counts if it is in the kind, in the address, or, for kinds 4 to 6, in the write data.
- R9: A `startReplay` pulse, or a low-to-high change of `modeCheck`, sets the replay pointer to entry 0. An access made in that same cycle is compared with entry 0.
- R10: An `endReplay` pulse in check mode sets `errMissing` when fewer entries were consumed than were logged.
- R11: Logging when `DEPTH` entries are already held drops the entry and sets `errOverflow`. The entry that fills the last slot does not set it.
- R12: All error flags are sticky. They stay set until `clearTrace`, whatever later accesses do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeCheck | input | 1 | 0 = record, 1 = check against trace |
| startReplay | input | 1 | Pulse: rewind replay pointer |
| endReplay | input | 1 | Pulse: test for unconsumed entries |
| clearTrace | input | 1 | Pulse: empty trace, clear flags |
| reqValid | input | 1 | Engine access valid |
| reqKind | input | 3 | Operation kind code |
| reqAddr | input | ADDR_W | Access address |
| reqWdata | input | DATA_W | Write data |
| rspData | output | DATA_W | Read data back to engine |
| memValid | output | 1 | Access issued to memory |
| memKind | output | 3 | Kind issued to memory |
| memAddr | output | ADDR_W | Address issued to memory |
| memWdata | output | DATA_W | Write data issued to memory |
| memRdata | input | DATA_W | Memory read data (same cycle) |
| errUnexpected | output | 1 | Access beyond end of trace |
| errMismatch | output | 1 | Access differs from trace entry |
| errMissing | output | 1 | Entries left at end of replay |
| errOverflow | output | 1 | Entry dropped, trace full |

## Verification
Before replay starts, the bench changes the memory contents. A design that takes read data from memory instead of the trace then returns the new value, not the recorded one.

A store-queue write sits between two logged accesses. If the design logged that write, or advanced the pointer on it during replay, the following read would mismatch. If it dropped the forward, the count of forwarded writes would fall short.

The bench toggles the mode and then replays again from the start. A design that does not rewind the pointer would report a mismatch, or an unexpected access, on correct traffic.

Overflow is tested at the exact boundary. The entry that fills the last slot must not set the flag, and the next entry must. The bench also checks that every flag stays set through later correct traffic.

// File: rtl/memTracePkg.sv
package memTracePkg;

  typedef enum logic [2:0] {
    OP_RD_L   = 3'd0,
    OP_RD_W   = 3'd1,
    OP_RD_B   = 3'd2,
    OP_RD_BFW = 3'd3,
    OP_WR_L   = 3'd4,
    OP_WR_W   = 3'd5,
    OP_WR_B   = 3'd6,
    OP_PREF   = 3'd7
  } memOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic recWr;     // log current access at recIdx
    logic fwdMem;    // drive the memory port
    logic useTrace;  // answer from trace entry at rdIdx
  } ctrlStrobes_t;

  function automatic logic isWriteOp(input logic [2:0] k);
    return (k == OP_WR_L) || (k == OP_WR_W) || (k == OP_WR_B);
  endfunction

endpackage

// File: rtl/traceDatapath.sv
module traceDatapath
  import memTracePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4096,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  ctrlStrobes_t      strobes,
  input  logic [IDX_W-1:0]  recIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] rspData,
  output logic              entryMatch,
  output logic              valueMatch,
  output logic              memValid,
  output logic [2:0]        memKind,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  logic [2:0]        kindMem [DEPTH];
  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DATA_W-1:0] valMem  [DEPTH];
  logic [DATA_W-1:0] recValue;

  always_comb begin
    if (isWriteOp(reqKind))        recValue = reqWdata;
    else if (reqKind == OP_PREF)   recValue = '0;
    else                           recValue = memRdata;
  end

  always_ff @(posedge clk) begin
    if (strobes.recWr) begin
      kindMem[recIdx] <= reqKind;
      addrMem[recIdx] <= reqAddr;
      valMem[recIdx]  <= recValue;
    end
  end

  assign entryMatch = (kindMem[rdIdx] == reqKind) && (addrMem[rdIdx] == reqAddr);
  assign valueMatch = (valMem[rdIdx] == reqWdata);
  assign rspData    = strobes.useTrace ? valMem[rdIdx] : memRdata;

  assign memValid = strobes.fwdMem;
  assign memKind  = reqKind;
  assign memAddr  = reqAddr;
  assign memWdata = reqWdata;

endmodule

// File: rtl/traceControl.sv
module traceControl
  import memTracePkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DEPTH   = 4096,
  parameter logic [ADDR_W-1:0] SQ_MASK = 32'hFC00_0000,
  parameter logic [ADDR_W-1:0] SQ_BASE = 32'hE000_0000,
  parameter int IDX_W   = $clog2(DEPTH),
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeCheck,
  input  logic              startReplay,
  input  logic              endReplay,
  input  logic              clearTrace,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              entryMatch,
  input  logic              valueMatch,
  output ctrlStrobes_t      strobes,
  output logic [IDX_W-1:0]  recIdx,
  output logic [IDX_W-1:0]  rdIdx,
  output logic              errUnexpected,
  output logic              errMismatch,
  output logic              errMissing,
  output logic              errOverflow
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] recCount, replayPtr, ptrEff;
  logic modeQ, restart, isWr, isSq, advance;
  logic unexpHit, mismHit, ovfHit, missHit;

  assign isWr    = isWriteOp(reqKind);
  assign isSq    = (reqAddr & SQ_MASK) == SQ_BASE;
  assign restart = startReplay || (modeCheck && !modeQ);
  assign ptrEff  = restart ? '0 : replayPtr;
  assign recIdx  = recCount[IDX_W-1:0];
  assign rdIdx   = ptrEff[IDX_W-1:0];
  assign missHit = endReplay && modeCheck && (ptrEff < recCount);

  always_comb begin
    strobes  = '0;
    advance  = 1'b0;
    unexpHit = 1'b0;
    mismHit  = 1'b0;
    ovfHit   = 1'b0;
    if (reqValid) begin
      if (!modeCheck) begin
        strobes.fwdMem = 1'b1;
        if (!(isWr && isSq)) begin
          if (recCount < FULL) strobes.recWr = !clearTrace;
          else                 ovfHit = 1'b1;
        end
      end else if (isWr && isSq) begin
        strobes.fwdMem = 1'b1;
      end else if (ptrEff >= recCount) begin
        unexpHit = 1'b1;
      end else begin
        strobes.useTrace = 1'b1;
        advance = 1'b1;
        mismHit = !entryMatch || (isWr && !valueMatch);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ         <= 1'b0;
      recCount      <= '0;
      replayPtr     <= '0;
      errUnexpected <= 1'b0;
      errMismatch   <= 1'b0;
      errMissing    <= 1'b0;
      errOverflow   <= 1'b0;
    end else begin
      modeQ <= modeCheck;
      if (clearTrace) begin
        recCount      <= '0;
        replayPtr     <= '0;
        errUnexpected <= 1'b0;
        errMismatch   <= 1'b0;
        errMissing    <= 1'b0;
        errOverflow   <= 1'b0;
      end else begin
        if (strobes.recWr) recCount <= recCount + 1'b1;
        replayPtr     <= advance ? ptrEff + 1'b1 : ptrEff;
        errUnexpected <= errUnexpected | unexpHit;
        errMismatch   <= errMismatch | mismHit;
        errMissing    <= errMissing | missHit;
        errOverflow   <= errOverflow | ovfHit;
      end
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (recCount < FULL) |-> !errOverflow);

  // R7
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    replayPtr <= recCount);

  // R12
  sticky_mismatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errMismatch && !clearTrace) |=> errMismatch);

  // R12
  sticky_unexp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errUnexpected && !clearTrace) |=> errUnexpected);

endmodule

// File: rtl/memTraceChecker.sv
module memTraceChecker
  import memTracePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4096,
  parameter logic [ADDR_W-1:0] SQ_MASK = 32'hFC00_0000,
  parameter logic [ADDR_W-1:0] SQ_BASE = 32'hE000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeCheck,
  input  logic              startReplay,
  input  logic              endReplay,
  input  logic              clearTrace,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              memValid,
  output logic [2:0]        memKind,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              errUnexpected,
  output logic              errMismatch,
  output logic              errMissing,
  output logic              errOverflow
);

  localparam int IDX_W = $clog2(DEPTH);

  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] recIdx, rdIdx;
  logic             entryMatch, valueMatch;

  traceControl #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .SQ_MASK(SQ_MASK), .SQ_BASE(SQ_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeCheck(modeCheck), .startReplay(startReplay),
    .endReplay(endReplay), .clearTrace(clearTrace), .reqValid(reqValid),
    .reqKind(reqKind), .reqAddr(reqAddr), .entryMatch(entryMatch),
    .valueMatch(valueMatch), .strobes(strobes), .recIdx(recIdx), .rdIdx(rdIdx),
    .errUnexpected(errUnexpected), .errMismatch(errMismatch),
    .errMissing(errMissing), .errOverflow(errOverflow)
  );

  traceDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .strobes(strobes), .recIdx(recIdx), .rdIdx(rdIdx),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memRdata(memRdata), .rspData(rspData), .entryMatch(entryMatch),
    .valueMatch(valueMatch), .memValid(memValid), .memKind(memKind),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  // R2
  rec_forward_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeCheck && reqValid) |-> memValid);

  // R5
  check_read_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCheck && reqValid && !isWriteOp(reqKind)) |-> !memValid);

  // R6
  check_wr_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCheck && memValid) |-> (isWriteOp(memKind) && ((memAddr & SQ_MASK) == SQ_BASE)));

endmodule

// File: tb/memTraceChecker_tb.sv
module memTraceChecker_tb;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeCheck = 1'b0, startReplay = 1'b0, endReplay = 1'b0, clearTrace = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqKind = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [DW-1:0] rspData, memWdata, memRdata;
  logic [AW-1:0] memAddr;
  logic [2:0] memKind;
  logic memValid, errUnexpected, errMismatch, errMissing, errOverflow;

  logic [DW-1:0] memKey = 32'h1111_0000;
  int memWrCount = 0;
  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign memRdata = memAddr ^ memKey;

  always @(posedge clk)
    if (memValid && memKind >= 3'd4 && memKind <= 3'd6) memWrCount <= memWrCount + 1;

  memTraceChecker #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .modeCheck(modeCheck), .startReplay(startReplay),
    .endReplay(endReplay), .clearTrace(clearTrace), .reqValid(reqValid),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqWdata(reqWdata), .rspData(rspData),
    .memValid(memValid), .memKind(memKind), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .errUnexpected(errUnexpected), .errMismatch(errMismatch),
    .errMissing(errMissing), .errOverflow(errOverflow)
  );

  typedef struct {
    bit          chkRsp;
    logic [DW-1:0] rsp;
    logic        mv;
    string       tag;
  } expItem_t;

  expItem_t sbQ[$];

  // monitor: compares the response of each access while it is held
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (reqValid && sbQ.size() > 0) begin
        expItem_t e;
        e = sbQ.pop_front();
        nTests++;
        if (memValid !== e.mv) begin
          nFail++;
          $display("FAIL %s memValid actual=%0b expected=%0b", e.tag, memValid, e.mv);
        end
        if (e.chkRsp) begin
          nTests++;
          if (rspData !== e.rsp) begin
            nFail++;
            $display("FAIL %s rspData actual=%h expected=%h", e.tag, rspData, e.rsp);
          end
        end
      end
    end
  end

  task automatic access(input logic [2:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit chk, input logic [DW-1:0] rsp, input logic mv, input string tag);
    expItem_t e;
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqWdata = d;
    e.chkRsp = chk; e.rsp = rsp; e.mv = mv; e.tag = tag;
    sbQ.push_back(e);
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); startReplay = 1'b1; @(posedge clk); #1 startReplay = 1'b0;
  endtask
  task automatic pulseEnd();
    @(negedge clk); endReplay = 1'b1; @(posedge clk); #1 endReplay = 1'b0;
  endtask
  task automatic pulseClear();
    @(negedge clk); clearTrace = 1'b1; @(posedge clk); #1 clearTrace = 1'b0;
  endtask
  task automatic setMode(input logic m);
    @(negedge clk); modeCheck = m;
  endtask

  task automatic checkFlags(input logic u, input logic m, input logic mi, input logic o, input string tag);
    @(negedge clk);
    #2;
    nTests++;
    if ({errUnexpected, errMismatch, errMissing, errOverflow} !== {u, m, mi, o}) begin
      nFail++;
      $display("FAIL %s flags{unexp,mism,miss,ovf} actual=%b expected=%b", tag,
               {errUnexpected, errMismatch, errMissing, errOverflow}, {u, m, mi, o});
    end
  endtask

  task automatic checkInt(input int act, input int exp, input string tag);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int wBase;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    checkFlags(0, 0, 0, 0, "R1 reset");
    checkInt(int'(memValid), 0, "R1 idle memValid");

    // record phase: R2 R3 R4
    access(3'd0, 32'h100, 0, 1, 32'h1111_0100, 1, "R2 rec read long");
    access(3'd5, 32'h200, 32'h1234, 0, 0, 1, "R2 rec write word");
    access(3'd7, 32'h300, 0, 0, 0, 1, "R2 rec prefetch");
    access(3'd4, 32'hE000_0010, 32'h55, 0, 0, 1, "R4 rec sq write fwd");
    access(3'd2, 32'h404, 0, 1, 32'h1111_0404, 1, "R2 rec read byte");
    checkFlags(0, 0, 0, 0, "R3 record flags");

    // replay with changed memory contents: R5 R6 R9
    memKey = 32'h2222_0000;
    setMode(1'b1);
    wBase = memWrCount;
    access(3'd0, 32'h100, 0, 1, 32'h1111_0100, 0, "R5 replay read from trace");
    access(3'd5, 32'h200, 32'h1234, 0, 0, 0, "R6 replay write not forwarded");
    access(3'd7, 32'h300, 0, 0, 0, 0, "R5 replay prefetch no mem");
    @(negedge clk);
    checkInt(memWrCount - wBase, 0, "R6 plain write not forwarded");
    access(3'd4, 32'hE000_0020, 32'h77, 0, 0, 1, "R6 replay sq write forwarded");
    access(3'd2, 32'h404, 0, 1, 32'h1111_0404, 0, "R4 sq write absent from trace");
    @(negedge clk);
    checkInt(memWrCount - wBase, 1, "R6 sq write count");
    pulseEnd();
    checkFlags(0, 0, 0, 0, "R10 full replay no missing");

    // beyond end of trace: R7
    access(3'd0, 32'h500, 0, 0, 0, 0, "R7 extra access");
    checkFlags(1, 0, 0, 0, "R7 unexpected");

    // kind mismatch after rewind: R8 R9 R12
    pulseStart();
    access(3'd1, 32'h100, 0, 0, 0, 0, "R8 kind differs");
    checkFlags(1, 1, 0, 0, "R8 kind mismatch, R12 unexpected sticky");
    access(3'd5, 32'h200, 32'h1234, 0, 0, 0, "R12 correct access after error");
    checkFlags(1, 1, 0, 0, "R12 flags stay set");

    // clear: R1
    pulseClear();
    checkFlags(0, 0, 0, 0, "R1 clear drops flags");
    access(3'd0, 32'h10, 0, 0, 0, 0, "R1 access on empty trace");
    checkFlags(1, 0, 0, 0, "R1 empty trace after clear");
    pulseClear();

    // missing and rewind-on-mode-entry: R10 R9 R8
    setMode(1'b0);
    memKey = 32'h3333_0000;
    access(3'd6, 32'h10, 32'hAB, 0, 0, 1, "R3 rec write byte");
    access(3'd1, 32'h20, 0, 1, 32'h3333_0020, 1, "R3 rec read word");
    setMode(1'b1);
    memKey = 32'h4444_0000;
    access(3'd6, 32'h10, 32'hAB, 0, 0, 0, "R8 matching write");
    pulseEnd();
    checkFlags(0, 0, 1, 0, "R10 missing entry");
    setMode(1'b0);
    setMode(1'b1);
    access(3'd6, 32'h10, 32'hAB, 0, 0, 0, "R9 rewind on mode entry write");
    access(3'd1, 32'h20, 0, 1, 32'h3333_0020, 0, "R9 rewind on mode entry read");
    checkFlags(0, 0, 1, 0, "R9 no mismatch after rewind");
    pulseStart();
    access(3'd6, 32'h10, 32'hAC, 0, 0, 0, "R8 write value differs");
    checkFlags(0, 1, 1, 0, "R8 value mismatch");

    // overflow boundary: R11
    pulseClear();
    setMode(1'b0);
    for (int i = 0; i < DEPTH; i++)
      access(3'd0, 32'h1000 + AW'(i * 4), 0, 1, (32'h1000 + DW'(i * 4)) ^ 32'h4444_0000, 1, "R11 fill");
    checkFlags(0, 0, 0, 0, "R11 full but no overflow");
    access(3'd0, 32'h2000, 0, 1, 32'h4444_2000, 1, "R11 extra record");
    checkFlags(0, 0, 0, 1, "R11 overflow set");

    repeat (2) @(negedge clk);
    checkInt(sbQ.size(), 0, "scoreboard drained");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule